// File: doc/BRIEF.md
# Three-Cell Series Pack Protection Controller

This block is the decision logic of a protector for a pack of series-connected lithium cells. Analog comparators sit in front of it and are already synchronized to its clock. Per cell, they report whether the cell sits above the charge-stop threshold and above its charge-resume level. They also report whether the cell sits below the discharge-stop threshold and at or above its discharge-resume level. Load-pin comparators report two things: the start of a discharge current (current level 1) and the presence of a charger (current level 3). A separate qualifier supplies an already-latched current fault.

From these inputs the controller tracks three conditions: charge-stop, discharge-stop and power-down. It drives the charge switch enable, the discharge switch enable, one bleed output per cell and a power-down flag. Each detection must persist for a programmable number of timebase ticks before it takes effect. The charge-side window is normally set about 25 times longer than the discharge-side window, roughly one second against forty milliseconds. An external control pin with strap-selected polarity can force both switches off.

Top module: `cellguard_ctrl`

## Requirements
- R1: After reset the discharge-stop and power-down conditions are active, so `dsg_en`=0 and `pwr_down`=1, with no bleed output set. `chg_en` is 1 unless it is inhibited.
- R2: Charge-stop is entered when some `cell_hi` bit is 1 while `chg_present` is 1 for `chg_dly` tick cycles. The condition is active from the clock edge of the last qualifying tick, and while it is active `chg_en` is 0. A `chg_dly` of 0 behaves like 1.
- R3: If every `cell_hi` bit or `chg_present` drops before the window expires, the charge-side tick count restarts from zero. The same holds for the discharge side when every `cell_lo` bit drops.
- R4: When charge-stop is entered, bit i of `bleed` is set for each cell i whose `cell_hi` bit is 1. That bit is cleared at the first edge where `cell_hi_rel[i]`=0 (the cell is at or below its resume level).
- R5: Charge-stop is released when no cell that has its bleed bit set still shows `cell_hi_rel`=1.
- R6: Charge-stop is released by `load_lvl1`=1 (a discharge has started), even while the flagged cell is still above its resume level. Its bleed bit is left unchanged.
- R7: Charge-stop is released when `chg_present` is 0. Discharge-stop and power-down are unaffected by this.
- R8: Discharge-stop and power-down are entered when some `cell_lo` bit is 1 for `dsg_dly` tick cycles. While discharge-stop is active, `dsg_en` is 0. A `dsg_dly` of 0 behaves like 1.
- R9: Power-down is cleared only by `load_lvl3`=1 (charger detected).
- R10: Discharge-stop clears only when all `cell_lo_rel` bits are 1 and power-down is either already clear or being cleared in the same cycle.
- R11: Charge-stop and discharge-stop can be active together. Both switches are then off.
- R12: `cur_fault`=1 forces `chg_en` and `dsg_en` to 0 in the same cycle.
- R13: The control pin reads 1 when it is floating. With `ctl_rev`=0 the switches are inhibited when `ctl_pin`=1. With `ctl_rev`=1 they are inhibited when `ctl_pin`=0. Inhibit forces both enables to 0 in the same cycle and leaves the condition state untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase strobe that advances the delay counters |
| chg_dly | input | DLY_W | Charge-stop window, in ticks |
| dsg_dly | input | DLY_W | Discharge-stop window, in ticks |
| cell_hi | input | NCELL | Cell is above the charge-stop threshold |
| cell_hi_rel | input | NCELL | Cell is above its charge-resume level |
| cell_lo | input | NCELL | Cell is below the discharge-stop threshold |
| cell_lo_rel | input | NCELL | Cell is at or above its discharge-resume level |
| load_lvl1 | input | 1 | Load pin at or above current level 1 (discharge start) |
| load_lvl3 | input | 1 | Load pin at or above current level 3 (charger detect) |
| cur_fault | input | 1 | Latched current fault from the qualifier |
| chg_present | input | 1 | Charger attached |
| ctl_pin | input | 1 | Control pin level, 1 when floating |
| ctl_rev | input | 1 | Control polarity strap |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| bleed | output | NCELL | Per-cell bleed drive |
| pwr_down | output | 1 | Power-down indicator |

## Verification
If the charge-side condition bit is stuck or wrong, `chg_en` disagrees with the expected value one clock after the window expires or a release event arrives. A miscounted tick window moves that edge by at least one tick. A bleed bit that is not cleared stays visible on `bleed` after a flagged cell drops to its resume level. A power-down flag that clears without `load_lvl3` shows up as `dsg_en` rising while no charger is detected, within one cycle of all cells reaching their resume level. Errors in the override path show up in the same cycle as a wrong enable whenever the control pin or the fault toggles.

// File: rtl/cellguard_pkg.sv
package cellguard_pkg;
   typedef struct packed {
      logic chg_stop;
      logic dsg_stop;
      logic pdn;
   } cg_cond_t;

   localparam cg_cond_t CG_COND_RESET = '{chg_stop: 1'b0, dsg_stop: 1'b1, pdn: 1'b1};
endpackage

// File: rtl/cellguard_dly_timer.sv
module cellguard_dly_timer #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             qual,
   input  logic [DLY_W-1:0] limit,
   output logic             expire
);
   localparam int CNT_W = DLY_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;

   assign cnt_inc = cnt_q + 1'b1;
   assign expire  = qual && tick && (cnt_inc >= {1'b0, limit});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!qual || expire) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_inc;
      end
   end
endmodule

// File: rtl/cellguard_bleed_bank.sv
module cellguard_bleed_bank #(
   parameter int NCELL = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_evt,
   input  logic [NCELL-1:0] cell_hi,
   input  logic [NCELL-1:0] cell_hi_rel,
   output logic [NCELL-1:0] bleed
);
   for (genvar gi = 0; gi < NCELL; gi++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bleed[gi] <= 1'b0;
         end else if (set_evt && cell_hi[gi]) begin
            bleed[gi] <= 1'b1;
         end else if (!cell_hi_rel[gi]) begin
            bleed[gi] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/cellguard_cond_track.sv
module cellguard_cond_track
   import cellguard_pkg::*;
#(
   parameter int NCELL = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chg_expire,
   input  logic             dsg_expire,
   input  logic [NCELL-1:0] bleed,
   input  logic [NCELL-1:0] cell_hi_rel,
   input  logic [NCELL-1:0] cell_lo_rel,
   input  logic             load_lvl1,
   input  logic             load_lvl3,
   input  logic             chg_present,
   output cg_cond_t         cond
);
   cg_cond_t cond_d;
   logic     flagged_high;
   logic     all_lo_rel;

   assign flagged_high = |(bleed & cell_hi_rel);
   assign all_lo_rel   = &cell_lo_rel;

   always_comb begin
      cond_d = cond;
      if (chg_expire) begin
         cond_d.chg_stop = 1'b1;
      end else if (cond.chg_stop && (load_lvl1 || !chg_present || !flagged_high)) begin
         cond_d.chg_stop = 1'b0;
      end
      if (dsg_expire) begin
         cond_d.dsg_stop = 1'b1;
         cond_d.pdn      = 1'b1;
      end else begin
         if (load_lvl3) begin
            cond_d.pdn = 1'b0;
         end
         if (all_lo_rel && (!cond.pdn || load_lvl3)) begin
            cond_d.dsg_stop = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cond <= CG_COND_RESET;
      end else begin
         cond <= cond_d;
      end
   end
endmodule

// File: rtl/cellguard_ctrl.sv
module cellguard_ctrl
   import cellguard_pkg::*;
#(
   parameter int NCELL = 3,
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [DLY_W-1:0] chg_dly,
   input  logic [DLY_W-1:0] dsg_dly,
   input  logic [NCELL-1:0] cell_hi,
   input  logic [NCELL-1:0] cell_hi_rel,
   input  logic [NCELL-1:0] cell_lo,
   input  logic [NCELL-1:0] cell_lo_rel,
   input  logic             load_lvl1,
   input  logic             load_lvl3,
   input  logic             cur_fault,
   input  logic             chg_present,
   input  logic             ctl_pin,
   input  logic             ctl_rev,
   output logic             chg_en,
   output logic             dsg_en,
   output logic [NCELL-1:0] bleed,
   output logic             pwr_down
);
   if (NCELL < 1) begin : g_bad_ncell
      $error("cellguard_ctrl: NCELL must be at least 1");
   end
   if (DLY_W < 1 || DLY_W > 30) begin : g_bad_dly
      $error("cellguard_ctrl: DLY_W must lie in 1..30");
   end

   cg_cond_t cond;
   logic     chg_qual;
   logic     dsg_qual;
   logic     chg_expire;
   logic     dsg_expire;
   logic     inhibit;

   assign chg_qual = (|cell_hi) && chg_present && !cond.chg_stop;
   assign dsg_qual = (|cell_lo) && !cond.dsg_stop;

   cellguard_dly_timer #(.DLY_W(DLY_W)) u_chg_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .qual   (chg_qual),
      .limit  (chg_dly),
      .expire (chg_expire)
   );

   cellguard_dly_timer #(.DLY_W(DLY_W)) u_dsg_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .qual   (dsg_qual),
      .limit  (dsg_dly),
      .expire (dsg_expire)
   );

   cellguard_bleed_bank #(.NCELL(NCELL)) u_bleed (
      .clk         (clk),
      .rst_n       (rst_n),
      .set_evt     (chg_expire),
      .cell_hi     (cell_hi),
      .cell_hi_rel (cell_hi_rel),
      .bleed       (bleed)
   );

   cellguard_cond_track #(.NCELL(NCELL)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .chg_expire  (chg_expire),
      .dsg_expire  (dsg_expire),
      .bleed       (bleed),
      .cell_hi_rel (cell_hi_rel),
      .cell_lo_rel (cell_lo_rel),
      .load_lvl1   (load_lvl1),
      .load_lvl3   (load_lvl3),
      .chg_present (chg_present),
      .cond        (cond)
   );

   assign inhibit  = ctl_rev ? !ctl_pin : ctl_pin;
   assign chg_en   = !cond.chg_stop && !cur_fault && !inhibit;
   assign dsg_en   = !cond.dsg_stop && !cur_fault && !inhibit;
   assign pwr_down = cond.pdn;
endmodule

// File: rtl/cellguard_ctrl_chk.sv
module cellguard_ctrl_chk #(
   parameter int NCELL = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NCELL-1:0] cell_hi,
   input logic [NCELL-1:0] cell_hi_rel,
   input logic             load_lvl3,
   input logic             cur_fault,
   input logic             ctl_pin,
   input logic             ctl_rev,
   input logic             chg_en,
   input logic             dsg_en,
   input logic [NCELL-1:0] bleed,
   input logic             pwr_down
);
   assert_fault_off_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cur_fault |-> (!chg_en && !dsg_en));

   assert_ctl_inhibit_R13: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_rev && !ctl_pin) || (!ctl_rev && ctl_pin)) |-> (!chg_en && !dsg_en));

   assert_pdn_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_down && !load_lvl3) |=> pwr_down);

   assert_pdn_dsg_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_down) |-> !dsg_en);

   for (genvar gi = 0; gi < NCELL; gi++) begin : g_bleed_chk
      assert_bleed_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (bleed[gi] && !cell_hi_rel[gi] && !cell_hi[gi]) |=> !bleed[gi]);
   end
endmodule

bind cellguard_ctrl cellguard_ctrl_chk #(.NCELL(NCELL)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cell_hi     (cell_hi),
   .cell_hi_rel (cell_hi_rel),
   .load_lvl3   (load_lvl3),
   .cur_fault   (cur_fault),
   .ctl_pin     (ctl_pin),
   .ctl_rev     (ctl_rev),
   .chg_en      (chg_en),
   .dsg_en      (dsg_en),
   .bleed       (bleed),
   .pwr_down    (pwr_down)
);

// File: tb/cellguard_ctrl_bench.sv
`timescale 1ns/1ps
module cellguard_ctrl_bench;
   localparam int NCELL = 3;
   localparam int DLY_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tick = 1'b0;
   logic [DLY_W-1:0] chg_dly = 8'd4;
   logic [DLY_W-1:0] dsg_dly = 8'd3;
   logic [NCELL-1:0] cell_hi = '0, cell_hi_rel = '0, cell_lo = '0, cell_lo_rel = '1;
   logic             load_lvl1 = 1'b0, load_lvl3 = 1'b0, cur_fault = 1'b0;
   logic             chg_present = 1'b0, ctl_pin = 1'b0, ctl_rev = 1'b0;
   logic             chg_en, dsg_en, pwr_down;
   logic [NCELL-1:0] bleed;

   cellguard_ctrl #(.NCELL(NCELL), .DLY_W(DLY_W)) u_cellguard_ctrl (
      .clk(clk), .rst_n(rst_n), .tick(tick), .chg_dly(chg_dly), .dsg_dly(dsg_dly),
      .cell_hi(cell_hi), .cell_hi_rel(cell_hi_rel), .cell_lo(cell_lo),
      .cell_lo_rel(cell_lo_rel), .load_lvl1(load_lvl1), .load_lvl3(load_lvl3),
      .cur_fault(cur_fault), .chg_present(chg_present), .ctl_pin(ctl_pin),
      .ctl_rev(ctl_rev), .chg_en(chg_en), .dsg_en(dsg_en), .bleed(bleed),
      .pwr_down(pwr_down)
   );

   always #4 clk = ~clk;

   int  n_checks = 0;
   int  n_errs = 0;
   bit  done = 1'b0;
   string tag = "R1";

   // reference state, expressed from the requirements
   bit             m_cs, m_ds, m_pd;
   bit [NCELL-1:0] m_bl;
   int             m_ccnt, m_dcnt;
   int             lvl [NCELL];   // 0 below stop, 1 below resume, 2 nominal, 3 above resume, 4 above stop

   function automatic bit inhib();
      return ctl_rev ? !ctl_pin : ctl_pin;
   endfunction
   function automatic bit exp_chg();
      return !m_cs && !cur_fault && !inhib();
   endfunction
   function automatic bit exp_dsg();
      return !m_ds && !cur_fault && !inhib();
   endfunction

   task automatic chk(input string what, input logic [7:0] act, input logic [7:0] expv);
      n_checks++;
      if (act !== expv) begin
         n_errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, expv, $time);
      end
   endtask

   task automatic apply_lvls();
      for (int i = 0; i < NCELL; i++) begin
         cell_lo[i]     = (lvl[i] == 0);
         cell_lo_rel[i] = (lvl[i] >= 2);
         cell_hi_rel[i] = (lvl[i] >= 3);
         cell_hi[i]     = (lvl[i] == 4);
      end
   endtask

   task automatic model_reset();
      m_cs = 0; m_ds = 1; m_pd = 1; m_bl = '0; m_ccnt = 0; m_dcnt = 0;
   endtask

   task automatic model_step();
      bit cq, dq, cx, dx;
      int clim, dlim;
      clim = (chg_dly == 0) ? 1 : int'(chg_dly);
      dlim = (dsg_dly == 0) ? 1 : int'(dsg_dly);
      cq = (|cell_hi) && chg_present && !m_cs;
      dq = (|cell_lo) && !m_ds;
      cx = 0; dx = 0;
      if (!cq) m_ccnt = 0;
      else if (tick) begin
         if (m_ccnt + 1 >= clim) begin cx = 1; m_ccnt = 0; end else m_ccnt++;
      end
      if (!dq) m_dcnt = 0;
      else if (tick) begin
         if (m_dcnt + 1 >= dlim) begin dx = 1; m_dcnt = 0; end else m_dcnt++;
      end
      if (cx) m_cs = 1;
      else if (m_cs && (load_lvl1 || !chg_present || !(|(m_bl & cell_hi_rel)))) m_cs = 0;
      if (dx) begin m_ds = 1; m_pd = 1; end
      else begin
         if ((&cell_lo_rel) && (!m_pd || load_lvl3)) m_ds = 0;
         if (load_lvl3) m_pd = 0;
      end
      for (int i = 0; i < NCELL; i++) begin
         if (cx && cell_hi[i]) m_bl[i] = 1;
         else if (!cell_hi_rel[i]) m_bl[i] = 0;
      end
   endtask

   // inputs are already set (after a negedge); check then let the edge pass
   task automatic cyc();
      #1;
      chk("chg_en", {7'd0, chg_en}, {7'd0, exp_chg()});
      chk("dsg_en", {7'd0, dsg_en}, {7'd0, exp_dsg()});
      chk("bleed", {5'd0, bleed}, {5'd0, m_bl});
      chk("pwr_down", {7'd0, pwr_down}, {7'd0, m_pd});
      model_step();
      @(negedge clk);
   endtask

   task automatic set_cell(input int i, input int v);
      lvl[i] = v; apply_lvls();
   endtask

   initial begin
      for (int i = 0; i < NCELL; i++) lvl[i] = 2;
      apply_lvls();
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick = 1'b1;

      tag = "R1";
      #1;
      chk("reset dsg_en", {7'd0, dsg_en}, 8'd0);
      chk("reset pwr_down", {7'd0, pwr_down}, 8'd1);
      chk("reset chg_en", {7'd0, chg_en}, 8'd1);
      chk("reset bleed", {5'd0, bleed}, 8'd0);
      @(negedge clk);

      tag = "R9";  // nominal cells, no charger: power-down holds
      repeat (4) cyc();
      chk("pdn held", {7'd0, pwr_down}, 8'd1);
      tag = "R10";
      load_lvl3 = 1; cyc(); load_lvl3 = 0; cyc();
      chk("dsg released", {7'd0, dsg_en}, 8'd1);

      tag = "R3";
      chg_present = 1; set_cell(0, 4);
      repeat (3) cyc();
      set_cell(0, 3); cyc();
      set_cell(0, 4); repeat (3) cyc();
      chk("restart keeps chg_en", {7'd0, chg_en}, 8'd1);
      tag = "R2"; cyc();
      chk("chg stop", {7'd0, chg_en}, 8'd0);
      tag = "R4";
      chk("bleed cell0", {5'd0, bleed}, 8'h01);
      tag = "R6";
      set_cell(0, 3); load_lvl1 = 1; cyc(); load_lvl1 = 0; cyc();
      chk("load release", {7'd0, chg_en}, 8'd1);
      chk("bleed kept", {5'd0, bleed}, 8'h01);
      tag = "R5";
      set_cell(0, 2); cyc();
      chk("bleed cleared", {5'd0, bleed}, 8'h00);
      set_cell(2, 4); repeat (4) cyc();
      set_cell(2, 2); cyc();
      chk("release by level", {7'd0, chg_en}, 8'd1);

      tag = "R11";
      set_cell(1, 4); repeat (4) cyc();
      set_cell(2, 0); repeat (3) cyc();
      chk("both off chg", {7'd0, chg_en}, 8'd0);
      chk("both off dsg", {7'd0, dsg_en}, 8'd0);
      tag = "R7";
      chg_present = 0; cyc();
      chk("charger removed chg_en", {7'd0, chg_en}, 8'd1);
      chk("dsg kept off", {7'd0, dsg_en}, 8'd0);
      tag = "R8";
      chk("power-down on", {7'd0, pwr_down}, 8'd1);
      set_cell(1, 2); set_cell(2, 2); load_lvl3 = 1; cyc(); load_lvl3 = 0; cyc();

      tag = "R12";
      cur_fault = 1; #1;
      chk("fault chg", {7'd0, chg_en}, 8'd0);
      chk("fault dsg", {7'd0, dsg_en}, 8'd0);
      cyc(); cur_fault = 0; cyc();

      tag = "R13";
      ctl_pin = 1; #1;
      chk("normal pol high", {7'd0, chg_en | dsg_en}, 8'd0);
      cyc();
      ctl_rev = 1; #1;
      chk("reverse pol float", {7'd0, chg_en & dsg_en}, 8'd1);
      cyc();
      ctl_pin = 0; #1;
      chk("reverse pol low", {7'd0, chg_en | dsg_en}, 8'd0);
      cyc(); ctl_rev = 0; cyc();

      tag = "R2";  // zero window behaves like one
      chg_dly = 0; chg_present = 1; set_cell(0, 4); cyc();
      chk("zero window", {7'd0, chg_en}, 8'd0);
      set_cell(0, 2); cyc(); cyc();
      chg_dly = 4;

      tag = "RAND R2 R4 R8 R10";
      void'($urandom(32'h5eed_0042));
      for (int n = 0; n < 6000; n++) begin
         tick = ($urandom_range(0, 1) == 1);
         for (int i = 0; i < NCELL; i++) begin
            if ($urandom_range(0, 7) == 0) begin
               if ($urandom_range(0, 1) == 1) begin if (lvl[i] < 4) lvl[i]++; end
               else begin if (lvl[i] > 0) lvl[i]--; end
            end
         end
         apply_lvls();
         if ($urandom_range(0, 15) == 0) chg_present = ~chg_present;
         load_lvl1 = ($urandom_range(0, 19) == 0);
         load_lvl3 = ($urandom_range(0, 11) == 0);
         if ($urandom_range(0, 40) == 0) cur_fault = ~cur_fault;
         if ($urandom_range(0, 50) == 0) ctl_pin = ~ctl_pin;
         if ($urandom_range(0, 200) == 0) ctl_rev = ~ctl_rev;
         cyc();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_errs++; n_checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end
endmodule